// File: doc/BRIEF.md
# Task-Driven Capture/Compare Timer

This block is an up-counter, 32 bits wide by default, for peripherals that are controlled by one-clock task pulses and that report through one-clock event pulses. In timer mode the counter advances on a tick from a fixed prescaler that divides the system clock. In counter mode it advances on an external COUNT pulse instead. START and STOP pulses gate the counting. A CLEAR pulse zeroes the value without stopping the timer.

A bank of capture/compare registers, four by default, serves two purposes. A CAPTURE pulse for register n copies the live count into that register. Every register is also compared against the count, and its COMPARE event pulses when the count moves onto the stored value. A register that holds zero therefore marks counter wraparound as well as a clear. Software reads and writes the registers through a small indexed port.

A capture and a clear may arrive together, for example so that an interval can be measured and the count restarted in one step. In that case the register receives the count as it was before the clear. A prescaler tick that falls in the same cycle is kept, so the counter restarts at 1.

Top module: `tick_capture_timer`

## Requirements
- R1: After reset the count is 0, the timer is stopped, every capture/compare register reads 0 and no compare event is asserted.
- R2: A START pulse begins counting and a STOP pulse halts it. If both pulses come in the same cycle, STOP wins. While stopped, the count holds its value.
- R3: In timer mode (`cnt_mode` = 0) a running counter increases by exactly one every PRE_DIV clocks. The prescaler phase is kept across stops and clears.
- R4: In counter mode (`cnt_mode` = 1) a running counter increases by one for each clock in which `task_count` is high. `task_count` has no effect in timer mode or while stopped.
- R5: A CLEAR pulse sets the count to 0 on the next clock. If an increment falls in the same cycle, the count is set to 1 instead.
- R6: A pulse on bit n of `task_capture` stores into register n the count as it stood in that cycle, before any clear or increment from the same cycle.
- R7: When `sw_we` is high, `sw_wdata` is written into the register that `sw_addr` selects (index n). `sw_rdata` always shows the register that `sw_addr` selects. A capture into the same register in the same cycle takes priority over the write.
- R8: Bit n of `evt_compare` is high for one clock, in the first cycle in which the count equals the value that register n held when the count changed. It does not repeat while the count stays on that value.
- R9: Counting past all ones wraps the count to 0. A register holding 0 then raises its compare event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_mode | input | 1 | 0 = advance on prescaler tick, 1 = advance on `task_count` |
| task_start | input | 1 | Pulse that enables counting |
| task_stop | input | 1 | Pulse that halts counting |
| task_clear | input | 1 | Pulse that zeroes the count |
| task_count | input | 1 | Increment pulse used in counter mode |
| task_capture | input | NUM_CC | Bit n pulse copies the count into register n |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | IDX_W | Register index for read and write |
| sw_wdata | input | CNT_W | Register write data |
| sw_rdata | output | CNT_W | Contents of the selected register |
| count_o | output | CNT_W | Live count |
| evt_compare | output | NUM_CC | Bit n pulses on a match with register n |

## Verification
The properties assume that task inputs are synchronous to `clk` and are sampled only at a rising edge. They may be held high for any number of cycles, and several may be high in the same cycle. The properties make no assumption about the order in which pulses arrive. The random stimulus drives every input from the falling edge only. It produces overlapping START/STOP, CLEAR/CAPTURE and write/capture combinations, and it writes small register values so that compare matches occur often. Directed sequences line up a clear with a prescaler tick and run a reduced-width counter through its wraparound.

// File: rtl/tct_pkg.sv
package tct_pkg;
    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } tct_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    generate
        if (PRE_DIV <= 1) begin : g_pass
            assign tick = en;
        end else begin : g_div
            localparam int PW = $clog2(PRE_DIV);
            localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

            typedef struct packed {
                logic [PW-1:0] phase;
            } pre_s;

            pre_s st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (en) begin
                    st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick = en && (st_q.phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/tct_core.sv
module tct_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_counter,
    input  logic             do_start,
    input  logic             do_stop,
    input  logic             do_clear,
    input  logic             pre_tick,
    input  logic             ext_count,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } core_s;

    core_s st_d, st_q;
    logic  step;

    always_comb begin
        st_d = st_q;
        step = st_q.run && (mode_counter ? ext_count : pre_tick);
        if (do_clear) begin
            st_d.cnt = step ? CNT_W'(1) : '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (do_stop) begin
            st_d.run = 1'b0;
        end else if (do_start) begin
            st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_q = st_q.run;
    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;
endmodule

// File: rtl/tct_ccbank.sv
module tct_ccbank #(
    parameter int CNT_W  = 32,
    parameter int NUM_CC = 4,
    localparam int IDX_W = tct_pkg::idx_width(NUM_CC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CC-1:0]              capture,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic [CNT_W-1:0]               cnt_q,
    input  logic [CNT_W-1:0]               cnt_d,
    output logic [NUM_CC-1:0][CNT_W-1:0]   cc_q,
    output logic [NUM_CC-1:0]              evt_q
);
    typedef struct packed {
        logic [NUM_CC-1:0][CNT_W-1:0] cc;
        logic [NUM_CC-1:0]            evt;
    } bank_s;

    bank_s st_d, st_q;
    logic  moved;

    always_comb begin
        st_d  = st_q;
        moved = (cnt_d != cnt_q);
        for (int n = 0; n < NUM_CC; n++) begin
            st_d.evt[n] = moved && (cnt_d == st_q.cc[n]);
            if (capture[n]) begin
                st_d.cc[n] = cnt_q;
            end else if (wr_en && (int'(wr_idx) == n)) begin
                st_d.cc[n] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_q  = st_q.cc;
    assign evt_q = st_q.evt;
endmodule

// File: rtl/tick_capture_timer.sv
module tick_capture_timer #(
    parameter int CNT_W   = 32,
    parameter int NUM_CC  = 4,
    parameter int PRE_DIV = 16,
    localparam int IDX_W  = tct_pkg::idx_width(NUM_CC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_mode,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              task_clear,
    input  logic              task_count,
    input  logic [NUM_CC-1:0] task_capture,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_addr,
    input  logic [CNT_W-1:0]  sw_wdata,
    output logic [CNT_W-1:0]  sw_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CC-1:0] evt_compare
);
    import tct_pkg::*;

    logic                         run_q;
    logic                         tick;
    logic                         pre_en;
    logic                         is_counter;
    logic [CNT_W-1:0]             cnt_d;
    logic [NUM_CC-1:0][CNT_W-1:0] cc_all;

    assign is_counter = (tct_mode_e'(cnt_mode) == MODE_COUNTER);
    assign pre_en     = run_q && !is_counter;

    tct_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (pre_en),
        .tick (tick)
    );

    tct_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_counter(is_counter),
        .do_start    (task_start),
        .do_stop     (task_stop),
        .do_clear    (task_clear),
        .pre_tick    (tick),
        .ext_count   (task_count),
        .run_q       (run_q),
        .cnt_q       (count_o),
        .cnt_d       (cnt_d)
    );

    tct_ccbank #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(task_capture),
        .wr_en  (sw_we),
        .wr_idx (sw_addr),
        .wr_data(sw_wdata),
        .cnt_q  (count_o),
        .cnt_d  (cnt_d),
        .cc_q   (cc_all),
        .evt_q  (evt_compare)
    );

    always_comb begin
        sw_rdata = '0;
        for (int n = 0; n < NUM_CC; n++) begin
            if (int'(sw_addr) == n) sw_rdata = cc_all[n];
        end
    end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
    parameter int CNT_W  = 32,
    parameter int NUM_CC = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cnt_mode,
    input logic                         task_stop,
    input logic                         task_clear,
    input logic                         task_count,
    input logic [NUM_CC-1:0]            task_capture,
    input logic                         run_q,
    input logic [CNT_W-1:0]             count_o,
    input logic [NUM_CC-1:0][CNT_W-1:0] cc_q,
    input logic [NUM_CC-1:0]            evt_compare
);
    p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        task_stop |=> !run_q);

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !task_clear) |=> $stable(count_o));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !task_clear |=> (count_o == $past(count_o) ||
                         count_o == CNT_W'($past(count_o) + 1'b1)));

    p_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && !task_count && !task_clear) |=> $stable(count_o));

    p_clear_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        task_clear |=> (count_o <= CNT_W'(1)));

    generate
        for (genvar n = 0; n < NUM_CC; n++) begin : g_cc
            p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
                task_capture[n] |=> (cc_q[n] == $past(count_o)));

            p_event_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
                evt_compare[n] |-> (count_o == $past(cc_q[n]) &&
                                    count_o != $past(count_o)));
        end
    endgenerate
endmodule

bind tick_capture_timer tct_checker #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_mode    (cnt_mode),
    .task_stop   (task_stop),
    .task_clear  (task_clear),
    .task_count  (task_count),
    .task_capture(task_capture),
    .run_q       (run_q),
    .count_o     (count_o),
    .cc_q        (cc_all),
    .evt_compare (evt_compare)
);

// File: tb/sim_tick_capture_timer.sv
`timescale 1ns/1ps
module sim_tick_capture_timer;
    localparam int W   = 10;
    localparam int N   = 4;
    localparam int DIV = 3;
    localparam int AW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          t_start = 1'b0, t_stop = 1'b0, t_clear = 1'b0, t_count = 1'b0;
    logic [N-1:0]  t_cap = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata, cnt_out;
    logic [N-1:0]  evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit           m_run;
    int           m_pre;
    logic [W-1:0] m_cnt;
    logic [W-1:0] m_cc [N];
    logic [N-1:0] m_evt;
    string        m_tag;

    always #2.5 clk = ~clk;

    tick_capture_timer #(.CNT_W(W), .NUM_CC(N), .PRE_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_mode(mode),
        .task_start(t_start), .task_stop(t_stop), .task_clear(t_clear),
        .task_count(t_count), .task_capture(t_cap),
        .sw_we(we), .sw_addr(addr), .sw_wdata(wdata), .sw_rdata(rdata),
        .count_o(cnt_out), .evt_compare(evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                                input bit clr, input bit inc);
        if (clr) return inc ? W'(1) : W'(0);
        return c + W'(inc);
    endfunction

    task automatic idle_inputs();
        t_start = 0; t_stop = 0; t_clear = 0; t_count = 0; t_cap = '0; we = 0;
    endtask

    task automatic sync_check(input logic [AW-1:0] a);
        @(negedge clk);
        chk(m_tag, 32'(cnt_out), 32'(m_cnt));
        chk("R8", 32'(evt), 32'(m_evt));
        addr = a;
        #0.5;
        chk("R7", 32'(rdata), 32'(m_cc[a]));
    endtask

    task automatic drive();
        bit tick, inc;
        logic [W-1:0] nc;
        tick = m_run && !mode && (m_pre == DIV - 1);
        if (m_run && !mode) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
        inc = m_run && (mode ? t_count : tick);
        nc = next_count(m_cnt, t_clear, inc);
        for (int n = 0; n < N; n++) begin
            m_evt[n] = (nc == m_cc[n]) && (nc != m_cnt);
            if (t_cap[n]) m_cc[n] = m_cnt;
            else if (we && addr == AW'(n)) m_cc[n] = wdata;
        end
        if (t_clear) m_tag = "R5";
        else if (inc && nc == '0) m_tag = "R9";
        else if (!m_run) m_tag = "R2";
        else m_tag = mode ? "R4" : "R3";
        m_run = t_stop ? 0 : (t_start ? 1 : m_run);
        m_cnt = nc;
    endtask

    task automatic rand_inputs();
        t_start = ($urandom_range(0, 9) == 0);
        t_stop  = ($urandom_range(0, 19) == 0);
        t_clear = ($urandom_range(0, 15) == 0);
        t_count = $urandom_range(0, 1);
        for (int n = 0; n < N; n++) t_cap[n] = ($urandom_range(0, 7) == 0);
        we    = ($urandom_range(0, 9) == 0);
        wdata = W'($urandom_range(0, 24));
        if ($urandom_range(0, 199) == 0) mode = ~mode;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [W-1:0] pre_val;
        seed = $urandom(32'h1F2E);
        m_run = 0; m_pre = 0; m_cnt = '0; m_evt = '0; m_tag = "R1";
        for (int n = 0; n < N; n++) m_cc[n] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state: every register and output
        for (int n = 0; n < N; n++) begin
            sync_check(AW'(n));
            chk("R1", 32'(rdata), 0);
            idle_inputs(); drive();
        end
        chk("R1", 32'(cnt_out), 0);

        // R2 start and stop together: stop wins, count holds
        sync_check('0); idle_inputs(); t_start = 1; t_stop = 1; drive();
        for (int i = 0; i < 8; i++) begin sync_check('0); idle_inputs(); drive(); end
        sync_check('0);
        chk("R2", 32'(cnt_out), 0);
        idle_inputs(); t_start = 1; drive();

        // R3 timer mode pacing over a span of ticks
        for (int i = 0; i < 3 * DIV; i++) begin sync_check('0); idle_inputs(); drive(); end
        sync_check('0);
        chk("R3", 32'(cnt_out), 32'(m_cnt));

        // R5/R6 clear and capture in the very cycle a tick lands
        idle_inputs();
        while (!(m_run && !mode && m_pre == DIV - 1)) begin drive(); sync_check('0); idle_inputs(); end
        pre_val = m_cnt;
        t_clear = 1; t_cap[0] = 1; drive();
        sync_check('0);
        chk("R5", 32'(cnt_out), 1);
        chk("R6", 32'(rdata), 32'(pre_val));
        idle_inputs(); drive();

        // R7 capture beats a write to the same register
        sync_check(AW'(1)); idle_inputs();
        pre_val = m_cnt; t_cap[1] = 1; we = 1; wdata = W'(9); drive();
        sync_check(AW'(1));
        chk("R7", 32'(rdata), 32'(pre_val));
        idle_inputs(); drive();

        // R9 wraparound in counter mode with a zero compare value
        sync_check(AW'(2)); idle_inputs();
        mode = 1; we = 1; wdata = '0; drive();
        for (int n = 0; n < N; n++) begin
            sync_check(AW'(n)); idle_inputs(); we = 1; wdata = W'(600 + n); drive();
        end
        sync_check(AW'(2)); idle_inputs(); we = 1; wdata = '0; drive();
        while (m_cnt != '1) begin sync_check(AW'(2)); idle_inputs(); t_count = 1; drive(); end
        sync_check(AW'(2)); idle_inputs(); t_count = 1; drive();
        sync_check(AW'(2));
        chk("R9", 32'(cnt_out), 0);
        chk("R9", 32'(evt[2]), 1);
        idle_inputs(); drive();
        sync_check(AW'(2));
        chk("R8", 32'(evt[2]), 0);
        idle_inputs(); drive();

        // R4 count pulses ignored in timer mode while stopped
        sync_check('0); idle_inputs(); mode = 0; t_stop = 1; drive();
        pre_val = m_cnt;
        for (int i = 0; i < 5; i++) begin sync_check('0); idle_inputs(); t_count = 1; drive(); end
        sync_check('0);
        chk("R4", 32'(cnt_out), 32'(pre_val));
        idle_inputs(); drive();

        // constrained random mix
        for (int i = 0; i < 40000; i++) begin
            sync_check(AW'($urandom_range(0, N - 1)));
            rand_inputs();
            drive();
        end
        sync_check('0);
        idle_inputs();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule